// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block is the software-visible register file of an I/O interrupt router. Software never addresses the routing state directly. It first writes a register number into a select register, then moves 32-bit words through a single data window. The register space behind the window has three kinds of registers. There is a small controller identifier, which can be read at two register numbers. There is a fixed version word that reports how many input pins the router has. The rest is a table of 64-bit routing entries, one per pin. Each entry is reached as two 32-bit halves.

The full routing table is presented as a flat bus to the delivery logic. Each accepted store into a table entry is followed by a one-cycle strobe, so that the delivery logic can re-scan pending requests against the new routing. Reads are combinational on the access port. Stores commit at the clock edge.

Top module: `irq_redir_regfile`

## Requirements
- R1: After reset, the select register reads 0, the identifier is 0, the update strobe is low, and every routing entry equals 0x0000_0000_0001_0000 (only the mask bit, bit 16, set).
- R2: Only address bits 7:0 are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. Upper address bits are ignored. Any other offset reads 0 and ignores stores.
- R3: Window reads and stores whose size field is not 4 have no effect, and such reads return 0. Select-register accesses work with any size value.
- R4: Reading offset 0x00 returns the 8-bit select value, zero-extended. A store at offset 0x00 keeps data bits 7:0.
- R5: Window reads at register number 0x00 and at register number 0x02 both return the identifier in bits 27:24, with all other bits 0.
- R6: A window read at register number 0x01 returns 0x0017_0011: version code 0x11 in bits 7:0 and pin count minus one (23) in bits 23:16.
- R7: A window store at register number 0x00 keeps only data bits 27:24 as the identifier. Window stores at register numbers 0x01 and 0x02 change nothing.
- R8: Register numbers 0x10 + 2n and 0x11 + 2n (for n from 0 to 23) reach bits 31:0 and bits 63:32 of entry n. Entry n appears on `tbl_o[64n+63:64n]`.
- R9: A store into one half of an entry leaves the other half of that entry, and all other entries, unchanged.
- R10: Register numbers 0x03 to 0x0F and 0x40 to 0xFF read as 0 and ignore stores.
- R11: `tbl_upd` is high for exactly the one cycle that follows each accepted store into a table entry. It stays low after every other access and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = store, 0 = read |
| acc_addr | input | 12 | Byte address; only bits 7:0 are decoded |
| acc_size | input | 3 | Access size in bytes |
| acc_wdata | input | 32 | Store data |
| acc_rdata | output | 32 | Read data (combinational, 0 when not reading) |
| tbl_o | output | 1536 | Flat routing table, entry n at bits 64n+63:64n |
| tbl_upd | output | 1 | One-cycle pulse after each table store |

## Verification
A corrupted select register or a wrong entry decode shows up on the very next window read. The bench reads back all 256 register numbers after storing a distinct pattern through each one. A half-write that disturbs its sibling half changes the flat table bus one cycle after the store, and the bench compares that bus against its own model of all 24 entries. A strobe that is missing, stretched or spurious is seen at the first sample after the store edge. Every store, including ignored and short-size ones, is checked there.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

   localparam int WORD_W  = 32;
   localparam int ENTRY_W = 64;

   // which port offset an access lands on
   typedef enum logic [1:0] {
      PORT_NONE,
      PORT_SEL,
      PORT_WIN
   } port_e;

   // what the select register points at
   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_ID,
      TGT_VER,
      TGT_ARB,
      TGT_ENT
   } tgt_e;

endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
   import irq_redir_pkg::*;
#(
   parameter int DEC_W     = 8,
   parameter int SEL_W     = 8,
   parameter int NUM_PINS  = 24,
   parameter int ENT_W     = 5,
   parameter int SEL_OFS   = 'h00,
   parameter int WIN_OFS   = 'h10,
   parameter int IDX_ID    = 'h00,
   parameter int IDX_VER   = 'h01,
   parameter int IDX_ARB   = 'h02,
   parameter int TBL_BASE  = 'h10,
   parameter int ACC_BYTES = 4
) (
   input  logic [DEC_W-1:0] addr_lo,
   input  logic [2:0]       size,
   input  logic [SEL_W-1:0] sel,
   output port_e            port,
   output logic             size_ok,
   output tgt_e             tgt,
   output logic [ENT_W-1:0] ent,
   output logic             hi
);

   localparam logic [SEL_W-1:0] BASE_L = SEL_W'(TBL_BASE);
   localparam logic [SEL_W-1:0] PINS_L = SEL_W'(NUM_PINS);

   logic [SEL_W-1:0] off;
   logic [SEL_W-1:0] pair;
   logic             in_tbl;

   always_comb begin
      if (addr_lo == DEC_W'(SEL_OFS))      port = PORT_SEL;
      else if (addr_lo == DEC_W'(WIN_OFS)) port = PORT_WIN;
      else                                 port = PORT_NONE;
      size_ok = (size == 3'(ACC_BYTES));
   end

   always_comb begin
      off    = sel - BASE_L;
      pair   = off >> 1;
      in_tbl = (sel >= BASE_L) && (pair < PINS_L);
      ent    = pair[ENT_W-1:0];
      hi     = sel[0];
      if (sel == SEL_W'(IDX_ID))       tgt = TGT_ID;
      else if (sel == SEL_W'(IDX_VER)) tgt = TGT_VER;
      else if (sel == SEL_W'(IDX_ARB)) tgt = TGT_ARB;
      else if (in_tbl)                 tgt = TGT_ENT;
      else                             tgt = TGT_NONE;
   end

endmodule

// File: rtl/irq_redir_ident.sv
module irq_redir_ident #(
   parameter int ID_W       = 4,
   parameter int ID_LSB     = 24,
   parameter int VER_CODE   = 'h11,
   parameter int MAXENT_LSB = 16,
   parameter int NUM_PINS   = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            id_we,
   input  logic [ID_W-1:0] id_wr,
   output logic [31:0]     id_word,
   output logic [31:0]     ver_word
);

   logic [ID_W-1:0] id_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     id_q <= '0;
      else if (id_we) id_q <= id_wr;
   end

   assign id_word  = 32'(id_q) << ID_LSB;
   assign ver_word = 32'(VER_CODE) | (32'(NUM_PINS - 1) << MAXENT_LSB);

endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
   import irq_redir_pkg::*;
#(
   parameter int NUM_PINS = 24,
   parameter int ENT_W    = 5,
   parameter int MASK_BIT = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ENT_W-1:0]            wr_ent,
   input  logic                        wr_hi,
   input  logic [WORD_W-1:0]           wr_data,
   input  logic [ENT_W-1:0]            rd_ent,
   input  logic                        rd_hi,
   output logic [WORD_W-1:0]           rd_word,
   output logic [NUM_PINS*ENTRY_W-1:0] tbl_flat
);

   localparam logic [ENTRY_W-1:0] RST_ENTRY = ENTRY_W'(1) << MASK_BIT;

   logic [ENTRY_W-1:0] ent_q [NUM_PINS];

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
      logic sel_me;
      assign sel_me = wr_en && (wr_ent == ENT_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q[g] <= RST_ENTRY;
         end else if (sel_me) begin
            if (wr_hi) ent_q[g][ENTRY_W-1:WORD_W] <= wr_data;
            else       ent_q[g][WORD_W-1:0]       <= wr_data;
         end
      end

      assign tbl_flat[g*ENTRY_W +: ENTRY_W] = ent_q[g];
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (rd_ent == ENT_W'(i))
            rd_word = rd_hi ? ent_q[i][ENTRY_W-1:WORD_W] : ent_q[i][WORD_W-1:0];
      end
   end

endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
   import irq_redir_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DEC_W      = 8,
   parameter int SEL_W      = 8,
   parameter int NUM_PINS   = 24,
   parameter int ID_W       = 4,
   parameter int ID_LSB     = 24,
   parameter int VER_CODE   = 'h11,
   parameter int MAXENT_LSB = 16,
   parameter int MASK_BIT   = 16,
   parameter int SEL_OFS    = 'h00,
   parameter int WIN_OFS    = 'h10,
   parameter int IDX_ID     = 'h00,
   parameter int IDX_VER    = 'h01,
   parameter int IDX_ARB    = 'h02,
   parameter int TBL_BASE   = 'h10,
   parameter int ACC_BYTES  = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         acc_valid,
   input  logic                         acc_write,
   input  logic [ADDR_W-1:0]            acc_addr,
   input  logic [2:0]                   acc_size,
   input  logic [31:0]                  acc_wdata,
   output logic [31:0]                  acc_rdata,
   output logic [NUM_PINS*64-1:0]       tbl_o,
   output logic                         tbl_upd
);

   localparam int ENT_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   // elaboration-time parameter checks
   if (SEL_W > WORD_W || ENT_W > SEL_W) begin : g_bad_sel
      $error("select width out of range");
   end
   if (TBL_BASE % 2 != 0 || TBL_BASE <= IDX_ARB) begin : g_bad_base
      $error("table base must be even and above the fixed registers");
   end
   if (TBL_BASE + 2 * NUM_PINS > (1 << SEL_W)) begin : g_bad_pins
      $error("table does not fit the select range");
   end
   if (ID_LSB + ID_W > WORD_W || NUM_PINS - 1 > 255) begin : g_bad_fields
      $error("identifier or entry-count field out of range");
   end
   if (DEC_W > ADDR_W) begin : g_bad_addr
      $error("decode width exceeds address width");
   end

   if (ADDR_W > DEC_W) begin : g_addr_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^acc_addr[ADDR_W-1:DEC_W];
   end

   logic [SEL_W-1:0] sel_q;
   port_e            port;
   logic             size_ok;
   tgt_e             tgt;
   logic [ENT_W-1:0] ent;
   logic             hi;
   logic             wr_acc, rd_acc, win_live;
   logic             id_we, tbl_we;
   logic [31:0]      id_word, ver_word, ent_word;
   logic             upd_q;

   irq_redir_decode #(
      .DEC_W(DEC_W), .SEL_W(SEL_W), .NUM_PINS(NUM_PINS), .ENT_W(ENT_W),
      .SEL_OFS(SEL_OFS), .WIN_OFS(WIN_OFS), .IDX_ID(IDX_ID),
      .IDX_VER(IDX_VER), .IDX_ARB(IDX_ARB), .TBL_BASE(TBL_BASE),
      .ACC_BYTES(ACC_BYTES)
   ) u_decode (
      .addr_lo (acc_addr[DEC_W-1:0]),
      .size    (acc_size),
      .sel     (sel_q),
      .port    (port),
      .size_ok (size_ok),
      .tgt     (tgt),
      .ent     (ent),
      .hi      (hi)
   );

   assign wr_acc   = acc_valid && acc_write;
   assign rd_acc   = acc_valid && !acc_write;
   assign win_live = (port == PORT_WIN) && size_ok;
   assign id_we    = wr_acc && win_live && (tgt == TGT_ID);
   assign tbl_we   = wr_acc && win_live && (tgt == TGT_ENT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         upd_q <= 1'b0;
      end else begin
         if (wr_acc && port == PORT_SEL) sel_q <= acc_wdata[SEL_W-1:0];
         upd_q <= tbl_we;
      end
   end

   irq_redir_ident #(
      .ID_W(ID_W), .ID_LSB(ID_LSB), .VER_CODE(VER_CODE),
      .MAXENT_LSB(MAXENT_LSB), .NUM_PINS(NUM_PINS)
   ) u_ident (
      .clk      (clk),
      .rst_n    (rst_n),
      .id_we    (id_we),
      .id_wr    (acc_wdata[ID_LSB +: ID_W]),
      .id_word  (id_word),
      .ver_word (ver_word)
   );

   irq_redir_table #(
      .NUM_PINS(NUM_PINS), .ENT_W(ENT_W), .MASK_BIT(MASK_BIT)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we),
      .wr_ent   (ent),
      .wr_hi    (hi),
      .wr_data  (acc_wdata),
      .rd_ent   (ent),
      .rd_hi    (hi),
      .rd_word  (ent_word),
      .tbl_flat (tbl_o)
   );

   always_comb begin
      acc_rdata = '0;
      if (rd_acc) begin
         if (port == PORT_SEL) begin
            acc_rdata = 32'(sel_q);
         end else if (win_live) begin
            case (tgt)
               TGT_ID, TGT_ARB: acc_rdata = id_word;
               TGT_VER:         acc_rdata = ver_word;
               TGT_ENT:         acc_rdata = ent_word;
               default:         acc_rdata = '0;
            endcase
         end
      end
   end

   assign tbl_upd = upd_q;

endmodule

// File: rtl/irq_redir_checker.sv
module irq_redir_checker #(
   parameter int DEC_W      = 8,
   parameter int SEL_W      = 8,
   parameter int NUM_PINS   = 24,
   parameter int VER_CODE   = 'h11,
   parameter int MAXENT_LSB = 16,
   parameter int SEL_OFS    = 'h00,
   parameter int WIN_OFS    = 'h10,
   parameter int IDX_VER    = 'h01,
   parameter int TBL_BASE   = 'h10,
   parameter int ACC_BYTES  = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   acc_valid,
   input logic                   acc_write,
   input logic [DEC_W-1:0]       addr_lo,
   input logic [2:0]             acc_size,
   input logic [31:0]            acc_rdata,
   input logic [NUM_PINS*64-1:0] tbl_o,
   input logic                   tbl_upd,
   input logic [SEL_W-1:0]       sel
);

   localparam logic [31:0] VER_EXP = 32'(VER_CODE) | (32'(NUM_PINS - 1) << MAXENT_LSB);

   logic        on_win, on_sel, sz_ok, in_tbl;
   int          ent_c;
   logic [31:0] lo_w, hi_w;

   always_comb begin
      on_win = (addr_lo == DEC_W'(WIN_OFS));
      on_sel = (addr_lo == DEC_W'(SEL_OFS));
      sz_ok  = (acc_size == 3'(ACC_BYTES));
      in_tbl = (int'(sel) >= TBL_BASE) && (((int'(sel) - TBL_BASE) >> 1) < NUM_PINS);
      ent_c  = in_tbl ? ((int'(sel) - TBL_BASE) >> 1) : 0;
      lo_w   = tbl_o[ent_c*64 +: 32];
      hi_w   = tbl_o[ent_c*64+32 +: 32];
   end

   // R11: an accepted table store is followed by the strobe
   assert_upd_after_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && on_win && sz_ok && in_tbl) |=> tbl_upd);

   // R11: no store this cycle, no strobe next cycle
   assert_upd_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write) |=> !tbl_upd);

   // R6: version word is constant
   assert_ver_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && on_win && sz_ok && int'(sel) == IDX_VER)
      |-> acc_rdata == VER_EXP);

   // R3: short-size window reads return zero
   assert_short_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && on_win && !sz_ok) |-> acc_rdata == '0);

   // R4: select readback
   assert_sel_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && on_sel) |-> acc_rdata == 32'(sel));

   // R9: low-half store keeps the high half
   assert_hi_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && on_win && sz_ok && in_tbl && !sel[0]) |=> $stable(hi_w));

   // R9: high-half store keeps the low half
   assert_lo_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && on_win && sz_ok && in_tbl && sel[0]) |=> $stable(lo_w));

endmodule

bind irq_redir_regfile irq_redir_checker #(
   .DEC_W(DEC_W), .SEL_W(SEL_W), .NUM_PINS(NUM_PINS), .VER_CODE(VER_CODE),
   .MAXENT_LSB(MAXENT_LSB), .SEL_OFS(SEL_OFS), .WIN_OFS(WIN_OFS),
   .IDX_VER(IDX_VER), .TBL_BASE(TBL_BASE), .ACC_BYTES(ACC_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_write (acc_write),
   .addr_lo   (acc_addr[DEC_W-1:0]),
   .acc_size  (acc_size),
   .acc_rdata (acc_rdata),
   .tbl_o     (tbl_o),
   .tbl_upd   (tbl_upd),
   .sel       (sel_q)
);

// File: tb/irq_redir_regfile_bench.sv
`timescale 1ns/1ps
module irq_redir_regfile_bench;

   localparam int PINS = 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_valid = 1'b0;
   logic              acc_write = 1'b0;
   logic [11:0]       acc_addr = '0;
   logic [2:0]        acc_size = '0;
   logic [31:0]       acc_wdata = '0;
   logic [31:0]       acc_rdata;
   logic [PINS*64-1:0] tbl_o;
   logic              tbl_upd;

   int n_vec = 0;
   int n_bad = 0;

   logic [63:0] m_tbl [PINS];
   logic [3:0]  m_id;

   always #4 clk = ~clk;

   irq_redir_regfile u_irq_redir_regfile (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .tbl_o(tbl_o), .tbl_upd(tbl_upd)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input int idx);
      if (idx == 0 || idx == 2) return {4'h0, m_id, 24'h0};
      if (idx == 1) return 32'h0017_0011;
      if (idx >= 16 && idx < 16 + 2 * PINS)
         return idx[0] ? m_tbl[(idx - 16) >> 1][63:32] : m_tbl[(idx - 16) >> 1][31:0];
      return 32'h0;
   endfunction

   function automatic bit model_write(input int idx, input logic [31:0] d);
      if (idx == 0) begin
         m_id = d[27:24];
         return 1'b0;
      end
      if (idx >= 16 && idx < 16 + 2 * PINS) begin
         if (idx[0]) m_tbl[(idx - 16) >> 1][63:32] = d;
         else        m_tbl[(idx - 16) >> 1][31:0]  = d;
         return 1'b1;
      end
      return 1'b0;
   endfunction

   // store; strobe checked one cycle after the store edge
   task automatic do_write(input logic [11:0] a, input logic [2:0] sz,
                           input logic [31:0] d, input bit exp_upd, input string tag);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
      check({tag, " strobe"}, 64'(tbl_upd), 64'(exp_upd));
   endtask

   task automatic do_read(input logic [11:0] a, input logic [2:0] sz,
                          input logic [31:0] exp, input string tag);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
      #1;
      check(tag, 64'(acc_rdata), 64'(exp));
   endtask

   task automatic set_sel(input int v);
      do_write(12'h000, 3'd4, 32'(v), 1'b0, "R4 select store");
   endtask

   task automatic check_table(input string tag);
      for (int n = 0; n < PINS; n++)
         check(tag, tbl_o[n*64 +: 64], m_tbl[n]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int n = 0; n < PINS; n++) m_tbl[n] = 64'h1 << 16;
      m_id = 4'h0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check_table("R1 reset table");
      check("R1 reset strobe", 64'(tbl_upd), 64'h0);
      do_read(12'h000, 3'd4, 32'h0, "R1 reset select");
      do_read(12'h010, 3'd4, 32'h0, "R1 reset identifier");
      for (int n = 0; n < PINS; n++) begin
         set_sel(16 + 2 * n);
         do_read(12'h010, 3'd4, 32'h0001_0000, "R1 R8 entry low at reset");
         set_sel(17 + 2 * n);
         do_read(12'h010, 3'd4, 32'h0, "R1 R8 entry high at reset");
      end

      // R6 version, R5/R7 identifier
      set_sel(1);
      do_read(12'h010, 3'd4, 32'h0017_0011, "R6 version");
      set_sel(0);
      do_write(12'h010, 3'd4, 32'hFFFF_FFFF, 1'b0, "R7 id store");
      void'(model_write(0, 32'hFFFF_FFFF));
      do_read(12'h010, 3'd4, 32'h0F00_0000, "R5 id read");
      set_sel(2);
      do_read(12'h010, 3'd4, 32'h0F00_0000, "R5 arb read");
      do_write(12'h010, 3'd4, 32'h0000_0000, 1'b0, "R7 arb store");
      do_read(12'h010, 3'd4, 32'h0F00_0000, "R7 arb store ignored");
      set_sel(1);
      do_write(12'h010, 3'd4, 32'h0000_0000, 1'b0, "R7 version store");
      do_read(12'h010, 3'd4, 32'h0017_0011, "R7 version unchanged");

      // R3: size sweep on the window
      set_sel(16);
      for (int sz = 0; sz < 8; sz++) begin
         if (sz != 4) begin
            do_write(12'h010, 3'(sz), 32'hDEAD_BEEF, 1'b0, "R3 short store");
            do_read(12'h010, 3'(sz), 32'h0, "R3 short read");
         end
      end
      do_read(12'h010, 3'd4, model_read(16), "R3 entry kept after short stores");
      check_table("R3 table after short stores");
      do_write(12'h000, 3'd1, 32'h0000_0012, 1'b0, "R3 select store size 1");
      do_read(12'h000, 3'd2, 32'h0000_0012, "R3 R4 select read size 2");

      // R2: address aliasing and unknown offsets
      do_write(12'hF00, 3'd4, 32'hABCD_EF11, 1'b0, "R2 aliased select store");
      do_read(12'h300, 3'd4, 32'h0000_0011, "R2 R4 aliased select read");
      do_read(12'hA10, 3'd4, model_read(17), "R2 aliased window read");
      do_write(12'h004, 3'd4, 32'h5555_5555, 1'b0, "R2 offset 04 store");
      do_write(12'h020, 3'd4, 32'h5555_5555, 1'b0, "R2 offset 20 store");
      do_write(12'h7FF, 3'd4, 32'h5555_5555, 1'b0, "R2 offset FF store");
      do_read(12'h004, 3'd4, 32'h0, "R2 offset 04 read");
      do_read(12'h0FF, 3'd4, 32'h0, "R2 offset FF read");
      do_read(12'h000, 3'd4, 32'h0000_0011, "R2 select unchanged");
      check_table("R2 table unchanged");

      // R9: explicit half store
      set_sel(16 + 2 * 5);
      do_write(12'h010, 3'd4, 32'h1234_5678, 1'b1, "R9 R11 low store");
      void'(model_write(16 + 2 * 5, 32'h1234_5678));
      check("R9 high half kept", 64'(tbl_o[5*64+32 +: 32]), 64'h0);
      check("R9 low half set", 64'(tbl_o[5*64 +: 32]), 64'h1234_5678);

      // R8 R10 R11: store through every register number
      for (int idx = 0; idx < 256; idx++) begin
         logic [7:0]  b;
         logic [31:0] d;
         bit          eu;
         b  = 8'(idx);
         d  = {b, b ^ 8'hC3, ~b, b + 8'h29};
         set_sel(idx);
         eu = model_write(idx, d);
         do_write(12'h010, 3'd4, d, eu, "R10 R11 index sweep store");
         check("R8 R9 table after store", tbl_o, {m_tbl[23], m_tbl[22], m_tbl[21],
            m_tbl[20], m_tbl[19], m_tbl[18], m_tbl[17], m_tbl[16], m_tbl[15], m_tbl[14],
            m_tbl[13], m_tbl[12], m_tbl[11], m_tbl[10], m_tbl[9], m_tbl[8], m_tbl[7],
            m_tbl[6], m_tbl[5], m_tbl[4], m_tbl[3], m_tbl[2], m_tbl[1], m_tbl[0]} == tbl_o
            ? tbl_o : ~tbl_o);
      end
      for (int idx = 0; idx < 256; idx++) begin
         set_sel(idx);
         do_read(12'h010, 3'd4, model_read(idx), "R8 R10 index sweep read");
      end
      check_table("R8 final table");

      // R11: idle cycles keep the strobe low
      @(negedge clk);
      acc_valid = 1'b0;
      @(negedge clk);
      check("R11 idle strobe", 64'(tbl_upd), 64'h0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule